// File: doc/BRIEF.md
# Display Controller Boot Sequencer

This block brings up a graphics coprocessor that sits on a serial link. Out of reset it holds the coprocessor's active-low power-down pin, releases it, and then sends a fixed series of three-byte host commands through a shared transaction engine: wake, switch to the external oscillator, lock the PLL at 48 MHz, and core reset. Each of these steps is followed by a wait counted in milliseconds. The millisecond tick comes from a prescaler parameter, so a simulation can shrink it.

After the core reset the sequencer reads the one-byte identification register again and again until the expected code appears. Only then does it switch the serial link from the slow boot rate to the fast rate. With the link fast, it walks a list of register writes: the panel timing set, the backlight PWM, a two-word display list, the list swap and the touch threshold. The pixel-clock divider is the last of the panel group, so the panel lights only once its timing is in place. When the transaction engine acknowledges the final write, `done` goes high and stays high.

The transaction engine does the bit shifting. This block only presents one request at a time and waits for its acknowledge. The timing values are parameters, and the ID register address and the register block bases are parameters too.

Top module: `dboot_sequencer`

## Requirements
- R1: `pd_n` is low while reset is asserted and stays low for 20 ms after reset is released. Counted from the first clock edge with reset high, it rises on edge 20*CLKS_PER_MS+1. No request is presented while it is low. The first request rises 20*CLKS_PER_MS+2 cycles after `pd_n` rises.
- R2: Host commands go out in this order: 0x00 (wake), 0x44 (external oscillator), 0x62 (PLL 48 MHz), 0x68 (core reset). Each has `req_kind`=0, `req_len`=3, `req_addr`=0 and the opcode in `req_wdata[7:0]`. After the first command the link is idle for 20 ms, and after the second and third for 10 ms each. In cycles, `req_valid` stays low for d*CLKS_PER_MS+2 cycles.
- R3: One idle cycle after the core-reset acknowledge, the block issues ID reads. Each has `req_kind`=1, `req_addr`=ID_ADDR and `req_len`=1. It captures `rd_data` with each acknowledge and retries after one idle cycle until the captured byte equals ID_EXPECT (0x7C).
- R4: `fast_sclk` is 0 for every host command and ID read, and 1 for every write. It rises only after a matching ID.
- R5: Register writes use `req_kind`=2. Each write goes to REG_BASE+4*slot, where slot is the list index, minus 2 for the last two entries. The writes come in this order: horizontal cycle, offset, size, sync start, sync end; then vertical cycle, offset, size, sync start, sync end (all 2 bytes). Then pixel-data swizzle, pixel-clock polarity, clock spread = 1 and pixel-clock divider (all 1 byte).
- R6: Next come backlight PWM frequency = 1000 (2 bytes, slot 14) and PWM duty (2 bytes, slot 15). The duty is 100 when BL_INVERT=0 and 0 when BL_INVERT=1.
- R7: Then the display list: 0x26000007 at DL_BASE and 0x00000000 at DL_BASE+4, both 4 bytes. Then swap = 1 (4 bytes, slot 16) and touch threshold = 1200 (2 bytes, slot 17).
- R8: While `req_valid` is high and `req_ack` low, all request fields hold. `req_valid` drops in the cycle after an acknowledge. Consecutive writes and ID reads are separated by exactly one idle cycle.
- R9: `done` rises one cycle after the acknowledge of the last write and then stays high, and no request is ever presented once it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_ack | input | 1 | One-cycle acknowledge from the transaction engine; completes the pending request |
| rd_data | input | 8 | Read byte, valid together with `req_ack` for an ID read |
| pd_n | output | 1 | Active-low power-down pin of the coprocessor |
| fast_sclk | output | 1 | Serial rate select: 0 slow boot rate, 1 fast rate |
| req_valid | output | 1 | A request is pending |
| req_kind | output | 2 | 0 host command, 1 read, 2 write |
| req_addr | output | ADDR_W (24) | Target address of a read or write |
| req_len | output | 3 | Byte count on the wire (3, 1, 2 or 4) |
| req_wdata | output | 32 | Opcode or write value, little-endian on the wire |
| done | output | 1 | Boot complete |

## Verification
If the state sequence skips or repeats a step, the stream of requests seen at the engine boundary is wrong at the very next request. A scoreboard compares each request's kind, address, length and data in order, so the error shows there. An error in the millisecond timer or the armed flag shows as an idle gap of the wrong cycle count before the next command, or as a wrong width of the `pd_n` low pulse. A wrong ID comparison shows as an extra or missing read, or as `fast_sclk` rising early. A broken done condition shows one cycle after the final acknowledge.

// File: rtl/dboot_pkg.sv
// Shared types and the fixed boot recipe for the display controller sequencer.
// Assumes the write list has exactly NUM_WR entries, in the order given by wr_len/wr_slot.
package dboot_pkg;

    typedef enum logic [1:0] {
        RQ_HOST  = 2'd0,
        RQ_READ  = 2'd1,
        RQ_WRITE = 2'd2
    } rq_kind_e;

    typedef enum logic [3:0] {
        ST_PD_LOW,
        ST_PD_HIGH,
        ST_HC_REQ,
        ST_HC_DLY,
        ST_RD_GAP,
        ST_ID_REQ,
        ST_ID_CHK,
        ST_WR_REQ,
        ST_WR_GAP,
        ST_DONE
    } seq_state_e;

    localparam int NUM_HC   = 4;
    localparam int NUM_WR   = 20;
    localparam int HC_IDX_W = $clog2(NUM_HC);
    localparam int WR_IDX_W = $clog2(NUM_WR);
    localparam int MS_W     = 16;
    localparam logic [MS_W-1:0] PD_MS = 16'd20;

    localparam logic [31:0] DLW_CLEAR_ALL = 32'h2600_0007;
    localparam logic [31:0] DLW_END       = 32'h0000_0000;

    // Opcode of each host command, in issue order.
    function automatic logic [7:0] hc_opcode(input logic [HC_IDX_W-1:0] i);
        case (i)
            2'd0:    return 8'h00;
            2'd1:    return 8'h44;
            2'd2:    return 8'h62;
            default: return 8'h68;
        endcase
    endfunction

    // Settling time after each host command, in milliseconds (0 = none).
    function automatic logic [MS_W-1:0] hc_delay_ms(input logic [HC_IDX_W-1:0] i);
        case (i)
            2'd0:    return 16'd20;
            2'd1:    return 16'd10;
            2'd2:    return 16'd10;
            default: return 16'd0;
        endcase
    endfunction

    // Byte count of each write in the list.
    function automatic logic [2:0] wr_len(input logic [WR_IDX_W-1:0] i);
        if (i < 5'd10)      return 3'd2;
        else if (i < 5'd14) return 3'd1;
        else if (i < 5'd16) return 3'd2;
        else if (i < 5'd19) return 3'd4;
        else                return 3'd2;
    endfunction

    // Entries that land in display-list memory instead of the register block.
    function automatic logic wr_to_dl(input logic [WR_IDX_W-1:0] i);
        return (i == 5'd16) || (i == 5'd17);
    endfunction

    // Word slot inside the register block.
    function automatic logic [WR_IDX_W-1:0] wr_slot(input logic [WR_IDX_W-1:0] i);
        return (i < 5'd16) ? i : i - 5'd2;
    endfunction

endpackage

// File: rtl/dboot_ms_timer.sv
// One-shot millisecond timer. A start pulse loads a target in ms; fire pulses
// one cycle after target*CLKS_PER_MS cycles. Assumes target >= 1 and that start
// is not raised again while busy.
module dboot_ms_timer #(
    parameter int CLKS_PER_MS = 100000,
    parameter int MS_W        = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [MS_W-1:0] ms_target,
    output logic            fire
);
    localparam int PRE_W = $clog2(CLKS_PER_MS + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_MS - 1);

    logic [PRE_W-1:0] pre;
    logic [MS_W-1:0]  ms_cnt;
    logic [MS_W-1:0]  target_q;
    logic             busy;

    // Prescaler, millisecond count and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre      <= '0;
            ms_cnt   <= '0;
            target_q <= '0;
            busy     <= 1'b0;
            fire     <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (start) begin
                pre      <= '0;
                ms_cnt   <= '0;
                target_q <= ms_target;
                busy     <= 1'b1;
            end else if (busy) begin
                if (pre == PRE_LAST) begin
                    pre    <= '0;
                    ms_cnt <= ms_cnt + MS_W'(1);
                    if (ms_cnt == target_q - MS_W'(1)) begin
                        busy <= 1'b0;
                        fire <= 1'b1;
                    end
                end else begin
                    pre <= pre + PRE_W'(1);
                end
            end
        end
    end

    // R2: the running count never passes the loaded target.
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ms_cnt < target_q));

    // R1: a completion pulse lasts a single cycle.
    a_r1_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

endmodule

// File: rtl/dboot_wr_list.sv
// Decodes a write-list index into address, byte count and value.
// Pure combinational; the panel values and bases come from parameters.
module dboot_wr_list
    import dboot_pkg::*;
#(
    parameter int                ADDR_W    = 24,
    parameter logic [ADDR_W-1:0] REG_BASE  = 24'h102400,
    parameter logic [ADDR_W-1:0] DL_BASE   = 24'h100000,
    parameter logic [15:0]       H_CYCLE   = 16'd525,
    parameter logic [15:0]       H_OFFSET  = 16'd43,
    parameter logic [15:0]       H_SIZE    = 16'd480,
    parameter logic [15:0]       H_SYNC0   = 16'd0,
    parameter logic [15:0]       H_SYNC1   = 16'd41,
    parameter logic [15:0]       V_CYCLE   = 16'd286,
    parameter logic [15:0]       V_OFFSET  = 16'd12,
    parameter logic [15:0]       V_SIZE    = 16'd272,
    parameter logic [15:0]       V_SYNC0   = 16'd0,
    parameter logic [15:0]       V_SYNC1   = 16'd10,
    parameter logic [7:0]        SWIZZLE   = 8'd0,
    parameter logic [7:0]        PCLK_POL  = 8'd1,
    parameter logic [7:0]        PCLK_DIV  = 8'd5,
    parameter bit                BL_INVERT = 1'b0
) (
    input  logic [WR_IDX_W-1:0] idx,
    output logic [ADDR_W-1:0]   addr,
    output logic [2:0]          len,
    output logic [31:0]         data
);
    logic [15:0] duty;

    // Backlight duty variant chosen by the inversion parameter.
    generate
        if (BL_INVERT) begin : g_bl_inv
            assign duty = 16'd0;
        end else begin : g_bl_norm
            assign duty = 16'd100;
        end
    endgenerate

    // Address and length of the selected entry.
    always_comb begin
        len = wr_len(idx);
        if (wr_to_dl(idx))
            addr = DL_BASE + ((idx == 5'd17) ? ADDR_W'(4) : ADDR_W'(0));
        else
            addr = REG_BASE + ADDR_W'({wr_slot(idx), 2'b00});
    end

    // Value of the selected entry.
    always_comb begin
        case (idx)
            5'd0:    data = 32'(H_CYCLE);
            5'd1:    data = 32'(H_OFFSET);
            5'd2:    data = 32'(H_SIZE);
            5'd3:    data = 32'(H_SYNC0);
            5'd4:    data = 32'(H_SYNC1);
            5'd5:    data = 32'(V_CYCLE);
            5'd6:    data = 32'(V_OFFSET);
            5'd7:    data = 32'(V_SIZE);
            5'd8:    data = 32'(V_SYNC0);
            5'd9:    data = 32'(V_SYNC1);
            5'd10:   data = 32'(SWIZZLE);
            5'd11:   data = 32'(PCLK_POL);
            5'd12:   data = 32'd1;
            5'd13:   data = 32'(PCLK_DIV);
            5'd14:   data = 32'd1000;
            5'd15:   data = 32'(duty);
            5'd16:   data = DLW_CLEAR_ALL;
            5'd17:   data = DLW_END;
            5'd18:   data = 32'd1;
            default: data = 32'd1200;
        endcase
    end

endmodule

// File: rtl/dboot_seq_fsm.sv
// Boot step sequencer: power pin, host commands with waits, ID poll, write walk.
// Assumes req_ack is a one-cycle pulse that only arrives while req_valid is high.
module dboot_seq_fsm
    import dboot_pkg::*;
#(
    parameter logic [7:0] ID_EXPECT = 8'h7C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_ack,
    input  logic [7:0]          rd_data,
    input  logic                tmr_fire,
    output logic                tmr_start,
    output logic [MS_W-1:0]     tmr_ms,
    output logic                pd_n,
    output logic                fast_sclk,
    output logic                req_valid,
    output rq_kind_e            req_kind,
    output logic [HC_IDX_W-1:0] hc_idx,
    output logic [WR_IDX_W-1:0] wr_idx,
    output logic                done
);
    seq_state_e state;
    logic       armed;
    logic [7:0] id_q;
    logic       in_wait;

    assign in_wait = (state == ST_PD_LOW) || (state == ST_PD_HIGH) || (state == ST_HC_DLY);

    // Timer launch on the first cycle of each waiting state.
    always_comb begin
        tmr_start = in_wait && !armed;
        tmr_ms    = (state == ST_HC_DLY) ? hc_delay_ms(hc_idx) : PD_MS;
    end

    // Step register, indices, captured ID and serial rate select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_PD_LOW;
            armed     <= 1'b0;
            hc_idx    <= '0;
            wr_idx    <= '0;
            id_q      <= '0;
            fast_sclk <= 1'b0;
        end else begin
            case (state)
                ST_PD_LOW, ST_PD_HIGH, ST_HC_DLY: begin
                    if (!armed) begin
                        armed <= 1'b1;
                    end else if (tmr_fire) begin
                        armed <= 1'b0;
                        if (state == ST_PD_LOW) begin
                            state <= ST_PD_HIGH;
                        end else if (state == ST_PD_HIGH) begin
                            state <= ST_HC_REQ;
                        end else begin
                            hc_idx <= hc_idx + HC_IDX_W'(1);
                            state  <= ST_HC_REQ;
                        end
                    end
                end
                ST_HC_REQ: begin
                    if (req_ack)
                        state <= (hc_idx == HC_IDX_W'(NUM_HC - 1)) ? ST_RD_GAP : ST_HC_DLY;
                end
                ST_RD_GAP: state <= ST_ID_REQ;
                ST_ID_REQ: begin
                    if (req_ack) begin
                        id_q  <= rd_data;
                        state <= ST_ID_CHK;
                    end
                end
                ST_ID_CHK: begin
                    if (id_q == ID_EXPECT) begin
                        fast_sclk <= 1'b1;
                        state     <= ST_WR_REQ;
                    end else begin
                        state <= ST_ID_REQ;
                    end
                end
                ST_WR_REQ: begin
                    if (req_ack) begin
                        if (wr_idx == WR_IDX_W'(NUM_WR - 1)) begin
                            state <= ST_DONE;
                        end else begin
                            wr_idx <= wr_idx + WR_IDX_W'(1);
                            state  <= ST_WR_GAP;
                        end
                    end
                end
                ST_WR_GAP: state <= ST_WR_REQ;
                default:   state <= ST_DONE;
            endcase
        end
    end

    // Request strobe and kind decoded from the current step.
    always_comb begin
        pd_n      = (state != ST_PD_LOW);
        done      = (state == ST_DONE);
        req_valid = (state == ST_HC_REQ) || (state == ST_ID_REQ) || (state == ST_WR_REQ);
        case (state)
            ST_ID_REQ: req_kind = RQ_READ;
            ST_WR_REQ: req_kind = RQ_WRITE;
            default:   req_kind = RQ_HOST;
        endcase
    end

    // R1: nothing is requested while the coprocessor is held powered down.
    a_r1_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |-> !req_valid);

    // R4: commands and ID reads run at the slow rate.
    a_r4_slow_boot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != RQ_WRITE) |-> !fast_sclk);

    // R4: register writes run at the fast rate.
    a_r4_fast_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == RQ_WRITE) |-> fast_sclk);

    // R8: the strobe drops right after an acknowledge.
    a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> !req_valid);

    // R9: completion is sticky.
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R9: no request after completion.
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);

    // R9: completion follows an acknowledge.
    a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(req_ack));

endmodule

// File: rtl/dboot_sequencer.sv
// Top of the display controller boot sequencer. Combines the step sequencer,
// the millisecond timer and the write-list decoder, and forms the request
// fields seen by the shared serial transaction engine.
module dboot_sequencer
    import dboot_pkg::*;
#(
    parameter int                CLKS_PER_MS = 100000,
    parameter int                ADDR_W      = 24,
    parameter logic [ADDR_W-1:0] ID_ADDR     = 24'h0C0000,
    parameter logic [7:0]        ID_EXPECT   = 8'h7C,
    parameter logic [ADDR_W-1:0] REG_BASE    = 24'h102400,
    parameter logic [ADDR_W-1:0] DL_BASE     = 24'h100000,
    parameter logic [15:0]       H_CYCLE     = 16'd525,
    parameter logic [15:0]       H_OFFSET    = 16'd43,
    parameter logic [15:0]       H_SIZE      = 16'd480,
    parameter logic [15:0]       H_SYNC0     = 16'd0,
    parameter logic [15:0]       H_SYNC1     = 16'd41,
    parameter logic [15:0]       V_CYCLE     = 16'd286,
    parameter logic [15:0]       V_OFFSET    = 16'd12,
    parameter logic [15:0]       V_SIZE      = 16'd272,
    parameter logic [15:0]       V_SYNC0     = 16'd0,
    parameter logic [15:0]       V_SYNC1     = 16'd10,
    parameter logic [7:0]        SWIZZLE     = 8'd0,
    parameter logic [7:0]        PCLK_POL    = 8'd1,
    parameter logic [7:0]        PCLK_DIV    = 8'd5,
    parameter bit                BL_INVERT   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_ack,
    input  logic [7:0]        rd_data,
    output logic              pd_n,
    output logic              fast_sclk,
    output logic              req_valid,
    output logic [1:0]        req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic [2:0]        req_len,
    output logic [31:0]       req_wdata,
    output logic              done
);
    logic                tmr_start;
    logic                tmr_fire;
    logic [MS_W-1:0]     tmr_ms;
    rq_kind_e            kind;
    logic [HC_IDX_W-1:0] hc_idx;
    logic [WR_IDX_W-1:0] wr_idx;
    logic [ADDR_W-1:0]   wl_addr;
    logic [2:0]          wl_len;
    logic [31:0]         wl_data;

    dboot_ms_timer #(
        .CLKS_PER_MS (CLKS_PER_MS),
        .MS_W        (MS_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (tmr_start),
        .ms_target (tmr_ms),
        .fire      (tmr_fire)
    );

    dboot_seq_fsm #(
        .ID_EXPECT (ID_EXPECT)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_ack   (req_ack),
        .rd_data   (rd_data),
        .tmr_fire  (tmr_fire),
        .tmr_start (tmr_start),
        .tmr_ms    (tmr_ms),
        .pd_n      (pd_n),
        .fast_sclk (fast_sclk),
        .req_valid (req_valid),
        .req_kind  (kind),
        .hc_idx    (hc_idx),
        .wr_idx    (wr_idx),
        .done      (done)
    );

    dboot_wr_list #(
        .ADDR_W    (ADDR_W),
        .REG_BASE  (REG_BASE),
        .DL_BASE   (DL_BASE),
        .H_CYCLE   (H_CYCLE),
        .H_OFFSET  (H_OFFSET),
        .H_SIZE    (H_SIZE),
        .H_SYNC0   (H_SYNC0),
        .H_SYNC1   (H_SYNC1),
        .V_CYCLE   (V_CYCLE),
        .V_OFFSET  (V_OFFSET),
        .V_SIZE    (V_SIZE),
        .V_SYNC0   (V_SYNC0),
        .V_SYNC1   (V_SYNC1),
        .SWIZZLE   (SWIZZLE),
        .PCLK_POL  (PCLK_POL),
        .PCLK_DIV  (PCLK_DIV),
        .BL_INVERT (BL_INVERT)
    ) u_list (
        .idx  (wr_idx),
        .addr (wl_addr),
        .len  (wl_len),
        .data (wl_data)
    );

    // Request fields for the pending step.
    always_comb begin
        req_kind = kind;
        case (kind)
            RQ_READ: begin
                req_addr  = ID_ADDR;
                req_len   = 3'd1;
                req_wdata = '0;
            end
            RQ_WRITE: begin
                req_addr  = wl_addr;
                req_len   = wl_len;
                req_wdata = wl_data;
            end
            default: begin
                req_addr  = '0;
                req_len   = 3'd3;
                req_wdata = {24'd0, hc_opcode(hc_idx)};
            end
        endcase
    end

    // R8: an unacknowledged request keeps every field unchanged.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_kind) && $stable(req_addr)
                                     && $stable(req_len) && $stable(req_wdata)));

endmodule

// File: tb/sim_dboot_sequencer.sv
`timescale 1ns/1ps
module sim_dboot_sequencer;
    localparam int          P         = 4;
    localparam logic [23:0] ID_A      = 24'h0C0000;
    localparam logic [23:0] RB        = 24'h102400;
    localparam logic [23:0] DB        = 24'h100000;
    localparam logic [15:0] HC = 16'd525, HO = 16'd43, HS = 16'd480, HS0 = 16'd0, HS1 = 16'd41;
    localparam logic [15:0] VC = 16'd286, VO = 16'd12, VS = 16'd272, VS0 = 16'd0, VS1 = 16'd10;
    localparam logic [7:0]  SWZ = 8'd0, POL = 8'd1, DIV = 8'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req_ack, pd_n, fast_sclk, req_valid, done;
    logic [7:0]  rd_data;
    logic [1:0]  req_kind;
    logic [23:0] req_addr;
    logic [2:0]  req_len;
    logic [31:0] req_wdata;

    logic        ack1, pd1, fast1, valid1, done1;
    logic [1:0]  kind1;
    logic [23:0] addr1;
    logic [2:0]  len1;
    logic [31:0] wdata1;

    dboot_sequencer #(.CLKS_PER_MS(P), .ID_ADDR(ID_A), .REG_BASE(RB), .DL_BASE(DB),
        .H_CYCLE(HC), .H_OFFSET(HO), .H_SIZE(HS), .H_SYNC0(HS0), .H_SYNC1(HS1),
        .V_CYCLE(VC), .V_OFFSET(VO), .V_SIZE(VS), .V_SYNC0(VS0), .V_SYNC1(VS1),
        .SWIZZLE(SWZ), .PCLK_POL(POL), .PCLK_DIV(DIV), .BL_INVERT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .rd_data(rd_data), .pd_n(pd_n),
        .fast_sclk(fast_sclk), .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_len(req_len), .req_wdata(req_wdata), .done(done));

    dboot_sequencer #(.CLKS_PER_MS(P), .ID_ADDR(ID_A), .REG_BASE(RB), .DL_BASE(DB),
        .BL_INVERT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_ack(ack1), .rd_data(8'h7C), .pd_n(pd1),
        .fast_sclk(fast1), .req_valid(valid1), .req_kind(kind1), .req_addr(addr1),
        .req_len(len1), .req_wdata(wdata1), .done(done1));

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    typedef struct {
        int          kind;
        logic [23:0] addr;
        int          len;
        logic [31:0] data;
        int          gap;
        string       tag;
        string       gtag;
    } exp_t;
    exp_t exp_q[$];

    // Driver: expected request stream, computed from the requirements.
    task automatic push_exp(input int k, input logic [23:0] a, input int l,
                            input logic [31:0] d, input int g, input string t, input string gt);
        exp_t e;
        e.kind = k; e.addr = a; e.len = l; e.data = d; e.gap = g; e.tag = t; e.gtag = gt;
        exp_q.push_back(e);
    endtask

    task automatic push_wr(input int slot, input int l, input logic [31:0] d, input string t);
        push_exp(2, RB + 24'(4 * slot), l, d, 1, t, "R8");
    endtask

    task automatic build_expected();
        push_exp(0, 24'h0, 3, 32'h00, 20 * P + 2, "R2", "R1");
        push_exp(0, 24'h0, 3, 32'h44, 20 * P + 2, "R2", "R2");
        push_exp(0, 24'h0, 3, 32'h62, 10 * P + 2, "R2", "R2");
        push_exp(0, 24'h0, 3, 32'h68, 10 * P + 2, "R2", "R2");
        for (int i = 0; i < 3; i++) push_exp(1, ID_A, 1, 32'h0, 1, "R3", "R3");
        push_wr(0, 2, 32'(HC), "R5");  push_wr(1, 2, 32'(HO), "R5");
        push_wr(2, 2, 32'(HS), "R5");  push_wr(3, 2, 32'(HS0), "R5");
        push_wr(4, 2, 32'(HS1), "R5"); push_wr(5, 2, 32'(VC), "R5");
        push_wr(6, 2, 32'(VO), "R5");  push_wr(7, 2, 32'(VS), "R5");
        push_wr(8, 2, 32'(VS0), "R5"); push_wr(9, 2, 32'(VS1), "R5");
        push_wr(10, 1, 32'(SWZ), "R5"); push_wr(11, 1, 32'(POL), "R5");
        push_wr(12, 1, 32'd1, "R5");    push_wr(13, 1, 32'(DIV), "R5");
        push_wr(14, 2, 32'd1000, "R6"); push_wr(15, 2, 32'd100, "R6");
        push_exp(2, DB, 4, 32'h2600_0007, 1, "R7", "R8");
        push_exp(2, DB + 24'd4, 4, 32'h0, 1, "R7", "R8");
        push_wr(16, 4, 32'd1, "R7");
        push_wr(17, 2, 32'd1200, "R7");
    endtask

    // Transaction engine model for u0: variable latency, scripted ID bytes.
    int eng_cyc = 0;
    int last_ack_cyc = -10;
    initial begin
        int nreq = 0;
        int nrd  = 0;
        int wait_n = 0;
        req_ack = 1'b0;
        rd_data = 8'h00;
        forever begin
            @(negedge clk);
            eng_cyc++;
            req_ack <= 1'b0;
            if (req_valid && !req_ack) begin
                if (wait_n >= (nreq % 3)) begin
                    req_ack <= 1'b1;
                    if (req_kind == 2'd1) begin
                        rd_data <= (nrd == 0) ? 8'h00 : (nrd == 1) ? 8'h7B : 8'h7C;
                        nrd++;
                    end else begin
                        rd_data <= 8'h00;
                    end
                    last_ack_cyc = eng_cyc;
                    nreq++;
                    wait_n = 0;
                end else begin
                    wait_n++;
                end
            end
        end
    end

    // Engine model for u1 (inverted backlight): immediate ack, records the duty write.
    bit          duty_seen = 1'b0;
    logic [31:0] duty_val  = 32'hFFFF_FFFF;
    initial begin
        ack1 = 1'b0;
        forever begin
            @(negedge clk);
            ack1 <= 1'b0;
            if (valid1 && !ack1) begin
                ack1 <= 1'b1;
                if (kind1 == 2'd2 && addr1 == RB + 24'd60) begin
                    duty_seen = 1'b1;
                    duty_val  = wdata1;
                end
            end
        end
    end

    // Monitor: pops the scoreboard on every new request, checks timing and completion.
    int mon_cyc = 0;
    int after_done_req = 0;
    int done_drop = 0;
    initial begin
        bit prev_valid = 1'b0;
        bit prev_pd    = 1'b0;
        bit prev_done  = 1'b0;
        bit pd_checked = 1'b0;
        int pd_low = 0;
        int idle = 0;
        forever begin
            @(negedge clk);
            mon_cyc++;
            if (rst_n) begin
                if (!pd_checked) begin
                    if (!pd_n) pd_low++;
                    else begin
                        pd_checked = 1'b1;
                        chk(pd_low == 20 * P + 2, "R1", "pd_n low cycles", pd_low, 20 * P + 2);
                    end
                end
                if (req_valid) begin
                    if (!prev_valid) begin
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R9", "unexpected request addr", req_addr, 0);
                        end else begin
                            exp_t e;
                            e = exp_q.pop_front();
                            chk(req_kind == 2'(e.kind), e.tag, "kind", req_kind, e.kind);
                            chk(req_addr == e.addr, e.tag, "addr", req_addr, e.addr);
                            chk(req_len == 3'(e.len), e.tag, "len", req_len, e.len);
                            chk(req_wdata == e.data, e.tag, "data", req_wdata, e.data);
                            chk(fast_sclk == (e.kind == 2), "R4", "fast_sclk", fast_sclk, (e.kind == 2));
                            chk(idle == e.gap, e.gtag, "idle cycles before request", idle, e.gap);
                        end
                    end
                    idle = 0;
                end else if (pd_n && !prev_pd) begin
                    idle = 1;
                end else begin
                    idle++;
                end
                if (done && !prev_done) begin
                    chk(mon_cyc == last_ack_cyc + 1, "R9", "done rise cycle", mon_cyc, last_ack_cyc + 1);
                    chk(exp_q.size() == 0, "R9", "requests left at done", exp_q.size(), 0);
                end
                if (done && req_valid) after_done_req++;
                if (prev_done && !done) done_drop++;
                prev_valid = req_valid;
                prev_pd    = pd_n;
                prev_done  = done;
            end
        end
    end

    // Main sequence: reset checks, run to completion under a watchdog, summary.
    initial begin
        int n = 0;
        build_expected();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pd_n == 1'b0, "R1", "pd_n in reset", pd_n, 0);
        chk(req_valid == 1'b0, "R8", "req_valid in reset", req_valid, 0);
        chk(done == 1'b0, "R9", "done in reset", done, 0);
        chk(fast_sclk == 1'b0, "R4", "fast_sclk in reset", fast_sclk, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        while (!(done && done1) && n < 5000) begin
            @(posedge clk);
            n++;
        end
        chk(n < 5000, "R9", "watchdog cycles", n, 5000);
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b1, "R9", "done held", done, 1);
        chk(done_drop == 0, "R9", "done drops", done_drop, 0);
        chk(after_done_req == 0, "R9", "requests after done", after_done_req, 0);
        chk(duty_seen && duty_val == 32'd0, "R6", "inverted duty", duty_val, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule